// File: doc/BRIEF.md
# Serial time-of-year BCD reader

This block gives a processor a slow, bit-serial view of the calendar time. The processor reads one status register again and again, and each read returns one more bit of an eight-byte BCD time record at a fixed bit position of the register. The other bits of the register are plain read/write storage.

The time record is taken from binary time inputs, and only when the internal bit pointer is at zero. A record therefore stays self-consistent while it is read out, even if the inputs move between reads. The record has eight bytes, in this order: a fixed hundredths byte, seconds, minutes, hours, day of week, day of month, month and year. Any write to the status register sends the pointer back to zero, so software can resynchronise at any time. The block does not count time itself; an external counter drives the inputs.

Top module: `toy_serial_reader`

## Requirements
- R1: After reset the pointer is zero, the held record and the stored status bits are all zero, and `rd_data_o` reads 0.
- R2: The time inputs are sampled into the held record only on a read that finds the pointer at zero. Every other read shifts out held bits unchanged, whatever the inputs do.
- R3: Each time field is held as two BCD digits of the input value modulo 100, with the tens digit in bits 7:4 and the units digit in bits 3:0.
- R4: Byte 0 of the record is loaded with 0x50 on every capture.
- R5: Byte order is 0 hundredths, 1 seconds, 2 minutes, 3 hours, 4 day of week, 5 day of month, 6 month, 7 year.
- R6: The month is held as given (1 to 12) and the year input (0 to 127) is held modulo 100.
- R7: Read number p after the pointer was zero (counting from 0) returns bit (p mod 8) of byte (p div 8), so bytes go out least significant bit first, byte 0 first.
- R8: The pointer wraps after 64 reads; the 65th read finds it at zero and takes a new capture.
- R9: A write to the status register sets the pointer to zero.
- R10: A read and a write in the same cycle return the bit at the pointer as it stood before the cycle, together with the stored bits as they stood before the write; the pointer then ends at zero.
- R11: The serial bit sits at bit position `SER_BIT` (default 4) of the read data. A write stores every other bit of `wr_data_i`; the written value of bit `SER_BIT` is dropped and has no effect on the serial bit.
- R12: `rd_data_o` is registered: it takes its new value on the clock edge that samples `rd_en_i` and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_en_i | input | 1 | Read strobe for the status register |
| wr_en_i | input | 1 | Write strobe for the status register |
| wr_data_i | input | DATA_W | Write data |
| sec_i | input | 6 | Seconds, binary 0 to 59 |
| min_i | input | 6 | Minutes, binary 0 to 59 |
| hour_i | input | 5 | Hours, binary 0 to 23 |
| wday_i | input | 3 | Day of week, binary 0 to 6 |
| mday_i | input | 5 | Day of month, binary 1 to 31 |
| mon_i | input | 4 | Month, binary 1 to 12 |
| year_i | input | 7 | Year, binary 0 to 127 |
| rd_data_o | output | DATA_W | Read data, serial bit at SER_BIT |

## Verification
The two functions that can meet in one cycle are the serial read, which advances the pointer and may capture, and the write, which clears it. The bench advances the pointer partway into a record, changes the time inputs, then raises both strobes together with new write data. It judges the returned bit against the old record and the other bits against the old stored value, then reads on and expects a 0x50 byte followed by seconds from the new inputs, which proves both the clear and the fresh capture.

// File: rtl/toy_pkg.sv
package toy_pkg;
  localparam int unsigned FIELD_W   = 7;
  localparam int unsigned NUM_BYTES = 8;

  typedef enum logic [2:0] {
    F_HSEC, F_SEC, F_MIN, F_HOUR, F_WDAY, F_MDAY, F_MON, F_YEAR
  } toy_field_e;

  function automatic logic [7:0] to_bcd(input logic [FIELD_W-1:0] v);
    logic [6:0] r;
    r = 7'(v % 7'd100);
    return {4'(r / 7'd10), 4'(r % 7'd10)};
  endfunction
endpackage

// File: rtl/toy_bcd_enc.sv
module toy_bcd_enc
  import toy_pkg::*;
#(
  parameter int unsigned    N_BYTES  = NUM_BYTES,
  parameter logic [7:0]     HSEC_VAL = 8'h50
) (
  input  logic [N_BYTES-2:0][FIELD_W-1:0] time_i,
  output logic [N_BYTES-1:0][7:0]         bcd_o
);
  assign bcd_o[F_HSEC] = HSEC_VAL;

  for (genvar g = 1; g < N_BYTES; g++) begin : g_field
    assign bcd_o[g] = to_bcd(time_i[g-1]);
  end
endmodule

// File: rtl/toy_bit_ptr.sv
module toy_bit_ptr #(
  parameter int unsigned TOTAL_BITS = 64,
  parameter int unsigned PTR_W      = $clog2(TOTAL_BITS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             clear_i,
  output logic [PTR_W-1:0] ptr_o,
  output logic             at_zero_o
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(TOTAL_BITS - 1);

  logic [PTR_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            ptr_q <= '0;
    else if (clear_i)       ptr_q <= '0;
    else if (step_i) begin
      if (ptr_q == LAST)    ptr_q <= '0;
      else                  ptr_q <= ptr_q + 1'b1;
    end
  end

  assign ptr_o     = ptr_q;
  assign at_zero_o = (ptr_q == '0);

  assert_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> ptr_q == '0);
  assert_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !clear_i && ptr_q != LAST) |=> ptr_q == PTR_W'($past(ptr_q) + 1'b1));
  assert_wrap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !clear_i && ptr_q == LAST) |=> ptr_q == '0);
endmodule

// File: rtl/toy_snap_store.sv
module toy_snap_store #(
  parameter int unsigned N_BYTES = 8,
  parameter int unsigned PTR_W   = $clog2(N_BYTES * 8)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cap_i,
  input  logic [N_BYTES-1:0][7:0] bcd_i,
  input  logic [PTR_W-1:0]        ptr_i,
  output logic                    bit_o
);
  logic [N_BYTES-1:0][7:0] bytes_q;
  logic [N_BYTES*8-1:0]    src;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    bytes_q <= '0;
    else if (cap_i) bytes_q <= bcd_i;
  end

  // Bypass the fresh record so the capturing read returns its own bit 0.
  assign src   = cap_i ? bcd_i : bytes_q;
  assign bit_o = src[ptr_i];

  assert_capture_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i |=> bytes_q == $past(bcd_i));
  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_i |=> $stable(bytes_q));
endmodule

// File: rtl/toy_serial_reader.sv
module toy_serial_reader
  import toy_pkg::*;
#(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned SER_BIT = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [5:0]        sec_i,
  input  logic [5:0]        min_i,
  input  logic [4:0]        hour_i,
  input  logic [2:0]        wday_i,
  input  logic [4:0]        mday_i,
  input  logic [3:0]        mon_i,
  input  logic [6:0]        year_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int unsigned     TOTAL_BITS = NUM_BYTES * 8;
  localparam int unsigned     PTR_W      = $clog2(TOTAL_BITS);
  localparam logic [DATA_W-1:0] SER_MASK = DATA_W'(1) << SER_BIT;

  logic [NUM_BYTES-2:0][FIELD_W-1:0] tvec;
  logic [NUM_BYTES-1:0][7:0]         bcd;
  logic [PTR_W-1:0]                  ptr;
  logic                              at_zero;
  logic                              cap;
  logic                              ser_bit;
  logic [DATA_W-1:0]                 status_q;
  logic [DATA_W-1:0]                 rd_q;

  assign tvec[F_SEC-1]  = FIELD_W'(sec_i);
  assign tvec[F_MIN-1]  = FIELD_W'(min_i);
  assign tvec[F_HOUR-1] = FIELD_W'(hour_i);
  assign tvec[F_WDAY-1] = FIELD_W'(wday_i);
  assign tvec[F_MDAY-1] = FIELD_W'(mday_i);
  assign tvec[F_MON-1]  = FIELD_W'(mon_i);
  assign tvec[F_YEAR-1] = FIELD_W'(year_i);

  toy_bcd_enc #(.N_BYTES(NUM_BYTES), .HSEC_VAL(8'h50)) u_enc (
    .time_i (tvec),
    .bcd_o  (bcd)
  );

  toy_bit_ptr #(.TOTAL_BITS(TOTAL_BITS), .PTR_W(PTR_W)) u_ptr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .step_i    (rd_en_i),
    .clear_i   (wr_en_i),
    .ptr_o     (ptr),
    .at_zero_o (at_zero)
  );

  assign cap = rd_en_i && at_zero;

  toy_snap_store #(.N_BYTES(NUM_BYTES), .PTR_W(PTR_W)) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cap_i  (cap),
    .bcd_i  (bcd),
    .ptr_i  (ptr),
    .bit_o  (ser_bit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      status_q <= '0;
    else if (wr_en_i) status_q <= wr_data_i & ~SER_MASK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_q <= '0;
    else if (rd_en_i) rd_q <= (status_q & ~SER_MASK) | (ser_bit ? SER_MASK : '0);
  end

  assign rd_data_o = rd_q;

  assert_rdata_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_data_o));
  assert_keep_bits_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !$isunknown(status_q)) |=> (rd_data_o & ~SER_MASK) == ($past(status_q) & ~SER_MASK));
endmodule

// File: tb/tb_toy_serial_reader.sv
module tb_toy_serial_reader;
  localparam int CLK_P = 10;
  localparam int DW    = 16;
  localparam int SER   = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rd_en = 1'b0;
  logic          wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [5:0]    sec = '0;
  logic [5:0]    mnt = '0;
  logic [4:0]    hour = '0;
  logic [2:0]    wday = '0;
  logic [4:0]    mday = '0;
  logic [3:0]    mon = '0;
  logic [6:0]    year = '0;
  logic [DW-1:0] rd_data;

  int total = 0;
  int bad   = 0;
  logic [7:0] got   [8];
  logic [7:0] exp_b [8];
  logic       last_bit;

  always #(CLK_P/2) clk = ~clk;

  toy_serial_reader #(.DATA_W(DW), .SER_BIT(SER)) dut (
    .clk_i(clk), .rst_ni(rst_n), .rd_en_i(rd_en), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .sec_i(sec), .min_i(mnt), .hour_i(hour),
    .wday_i(wday), .mday_i(mday), .mon_i(mon), .year_i(year),
    .rd_data_o(rd_data)
  );

  function automatic logic [7:0] bcd(input int v);
    int r;
    r = v % 100;
    return 8'(((r / 10) << 4) | (r % 10));
  endfunction

  task automatic chk(input string req, input int act, input int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic set_time(input int s, input int m, input int h, input int wd,
                          input int md, input int mo, input int y);
    @(negedge clk);
    sec = 6'(s); mnt = 6'(m); hour = 5'(h); wday = 3'(wd);
    mday = 5'(md); mon = 4'(mo); year = 7'(y);
  endtask

  task automatic calc_exp();
    exp_b[0] = 8'h50;
    exp_b[1] = bcd(int'(sec));
    exp_b[2] = bcd(int'(mnt));
    exp_b[3] = bcd(int'(hour));
    exp_b[4] = bcd(int'(wday));
    exp_b[5] = bcd(int'(mday));
    exp_b[6] = bcd(int'(mon));
    exp_b[7] = bcd(int'(year));
  endtask

  task automatic rd();
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
    last_bit = rd_data[SER];
  endtask

  task automatic wr(input logic [DW-1:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  // Reads bits p0..p0+n-1 of the record, filling got[] LSB first.
  task automatic read_bits(input int p0, input int n);
    for (int i = p0; i < p0 + n; i++) begin
      rd();
      got[i/8][i%8] = last_bit;
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    chk("R1 rd_data after reset", int'(rd_data), 0);
    rst_n = 1'b1;

    // R1/R4/R5/R3/R7: first frame straight out of reset
    set_time(37, 5, 23, 6, 31, 12, 99);
    calc_exp();
    read_bits(0, 64);
    for (int b = 0; b < 8; b++) chk($sformatf("R5 R3 R7 byte %0d", b), int'(got[b]), int'(exp_b[b]));
    chk("R1 R4 hundredths", int'(got[0]), 8'h50);

    // R8: pointer wrapped, next read recaptures
    set_time(8, 59, 0, 0, 1, 1, 0);
    calc_exp();
    read_bits(0, 64);
    for (int b = 0; b < 8; b++) chk($sformatf("R8 recapture byte %0d", b), int'(got[b]), int'(exp_b[b]));

    // R2: inputs change mid-frame, record must not follow
    wr('0);
    set_time(12, 34, 10, 3, 15, 7, 21);
    calc_exp();
    read_bits(0, 8);
    set_time(45, 1, 2, 4, 9, 3, 88);
    read_bits(8, 56);
    for (int b = 0; b < 8; b++) chk($sformatf("R2 held byte %0d", b), int'(got[b]), int'(exp_b[b]));

    // R3/R6: exhaustive per-field sweeps
    for (int v = 0; v < 60; v++) begin
      wr('0); set_time(v, v, 0, 0, 1, 1, 0); read_bits(0, 24);
      chk("R3 seconds", int'(got[1]), int'(bcd(v)));
      chk("R3 minutes", int'(got[2]), int'(bcd(v)));
    end
    for (int v = 0; v < 24; v++) begin
      wr('0); set_time(0, 0, v, v % 7, 1, 1, 0); read_bits(0, 40);
      chk("R3 hours", int'(got[3]), int'(bcd(v)));
      chk("R3 weekday", int'(got[4]), int'(bcd(v % 7)));
    end
    for (int v = 1; v < 32; v++) begin
      wr('0); set_time(0, 0, 0, 0, v, (v % 12) + 1, 0); read_bits(0, 56);
      chk("R3 day of month", int'(got[5]), int'(bcd(v)));
      chk("R6 month", int'(got[6]), int'(bcd((v % 12) + 1)));
    end
    for (int v = 0; v < 128; v++) begin
      wr('0); set_time(0, 0, 0, 0, 1, 1, v); read_bits(0, 64);
      chk("R6 year modulo 100", int'(got[7]), int'(bcd(v % 100)));
    end

    // R9: write mid-frame resets pointer and forces new capture
    wr('0);
    set_time(1, 2, 3, 4, 5, 6, 7);
    read_bits(0, 20);
    set_time(42, 2, 3, 4, 5, 6, 7);
    calc_exp();
    wr('0);
    read_bits(0, 16);
    chk("R9 byte0 after write", int'(got[0]), 8'h50);
    chk("R9 seconds recaptured", int'(got[1]), int'(bcd(42)));

    // R10: read and write together
    wr(16'h1200);
    set_time(26, 2, 3, 4, 5, 6, 7);  // seconds 0x26: bit 2 is 1
    read_bits(0, 10);
    set_time(53, 2, 3, 4, 5, 6, 7);
    @(negedge clk); rd_en = 1'b1; wr_en = 1'b1; wr_data = 16'hA5A0;
    @(negedge clk); rd_en = 1'b0; wr_en = 1'b0;
    chk("R10 bit from old pointer", int'(rd_data[SER]), 1);
    chk("R10 old stored bits", int'(rd_data & ~16'(1 << SER)), 16'h1200);
    read_bits(0, 16);
    chk("R10 pointer cleared byte0", int'(got[0]), 8'h50);
    chk("R10 new capture seconds", int'(got[1]), int'(bcd(53)));

    // R11: stored bits and dropped serial position
    wr(16'hFFFF);
    rd();
    chk("R11 stored bits", int'(rd_data & ~16'(1 << SER)), int'(16'hFFFF & ~16'(1 << SER)));
    chk("R11 serial bit ignores write", int'(last_bit), 0);   // bit0 of 0x50
    read_bits(1, 4);
    chk("R11 serial bit4 of 0x50", int'(last_bit), 1);
    wr(16'h0010);
    rd();
    chk("R11 write of serial bit only", int'(rd_data), 0);

    // R12: output holds without a read
    wr(16'h0300);
    rd();
    chk("R12 value after read", int'(rd_data), 16'h0300);
    wr(16'h7C00);
    set_time(9, 9, 9, 1, 9, 9, 9);
    repeat (3) @(negedge clk);
    chk("R12 held without read", int'(rd_data), 16'h0300);
    rd();
    chk("R12 updates on read", int'(rd_data), 16'h7C00);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule